// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. A clock enable, `tick_en`, pulses sixteen times per bit period and paces all receive timing. The raw line goes through a two-flop synchronizer before any other logic sees it. A falling edge seen on a tick opens a candidate start bit. The candidate is kept only if the line stays low for half a bit. The receiver then samples every following bit near its middle, checks the optional parity bit and the stop bit, and hands the character to a buffer register with a data-ready flag.

Word length (5 to 8 bits) and parity mode (none, even or odd) come from static configuration inputs. The host reads the buffer and pulses `rd_ack` to release it. Parity and framing status travel with each character. If a character completes before the previous one was released, an overrun flag is set.

The framing state machine has five states. `ST_IDLE` waits for a tick-sampled falling edge. `ST_START` counts low ticks: it returns to `ST_IDLE` on a high tick (false start) and moves to `ST_DATA` when the eighth low tick is reached. `ST_DATA` samples one bit every 16 ticks. After the last data bit it moves to `ST_PARITY` if parity is enabled, otherwise to `ST_STOP`. `ST_PARITY` samples one bit and moves to `ST_STOP`. `ST_STOP` samples the stop bit at its centre, emits the character and returns to `ST_IDLE` at once.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset `rx_ready`, `parity_err`, `frame_err` and `overrun_err` are 0 and `rx_data` is 0.
- R2: `rxd_raw` passes through a two-flop synchronizer. A high-to-low change of that synchronized line, seen on a tick, starts a candidate start bit. If the line goes high before 8 consecutive low ticks, the receiver drops the candidate, returns to idle and produces no character.
- R3: Once the eighth low tick is reached the start bit is accepted. The first data bit is sampled 16 ticks later, and each later bit 16 ticks after the previous sample point.
- R4: `cfg_len` selects 5 + `cfg_len` data bits (0 gives 5 bits, 3 gives 8 bits). The first received bit is `rx_data[0]`, and bits above the word length read as 0.
- R5: `cfg_par` 1 selects even parity and 2 selects odd parity; 0 and 3 mean no parity bit. When parity is enabled, `parity_err` is 1 exactly when the data bits plus the parity bit do not have the selected parity. With no parity it is 0.
- R6: A stop bit sampled low gives `frame_err` = 1; a stop bit sampled high gives 0. The character is delivered in both cases.
- R7: The receiver looks for the next start edge from the centre of the first stop bit. A start edge that arrives 12 ticks after the stop bit begins is received correctly.
- R8: A completed character is loaded into the buffer and `rx_ready` goes to 1. `parity_err` and `frame_err` hold that character's status until the next character is loaded.
- R9: A one-cycle `rd_ack` clears `rx_ready` and `overrun_err`. If a character completes in the same cycle, the completion wins.
- R10: A character that completes while `rx_ready` is 1 overwrites the buffer and sets `overrun_err` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Sixteen-times-baud sample enable |
| rxd_raw | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Data bits minus five |
| cfg_par | input | 2 | 0/3 none, 1 even, 2 odd |
| rd_ack | input | 1 | Host has read the buffer |
| rx_data | output | 8 | Buffered character |
| rx_ready | output | 1 | Buffer holds an unread character |
| parity_err | output | 1 | Parity mismatch for buffered character |
| frame_err | output | 1 | Stop bit of buffered character was low |
| overrun_err | output | 1 | Unread character was overwritten |

## Verification
The embedded assertions check on every cycle that:
- a high tick during start qualification always returns to idle;
- a stop-bit sample always returns to idle;
- delivered characters carry no bits above the word length;
- `rx_ready` rises only on a completed character;
- `rd_ack` clears the ready and overrun flags;
- a completion while ready always sets overrun.

Only the bench scenarios can show the values themselves: the bit order, the parity verdict for each mode and word length, that a short glitch is rejected while a long low is accepted, and that a frame following a shortened stop bit is caught.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;

    localparam logic [1:0] PAR_NONE0 = 2'd0;
    localparam logic [1:0] PAR_EVEN  = 2'd1;
    localparam logic [1:0] PAR_ODD   = 2'd2;

    function automatic logic parity_on(input logic [1:0] mode);
        return (mode == PAR_EVEN) || (mode == PAR_ODD);
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= din;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import serial_rx_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    output logic              done,
    output logic [DATA_W-1:0] char_out,
    output logic              par_bad,
    output logic              stop_bad
);
    localparam int CNT_W    = $clog2(OSR);
    localparam int IDX_W    = $clog2(DATA_W);
    localparam int HALF     = OSR / 2;
    localparam int MIN_BITS = DATA_W - 3;

    rx_state_t         state, next_state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [IDX_W-1:0]  last_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_acc;
    logic              par_flag;
    logic              line_prev;
    logic              mid;

    assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_len);
    assign mid      = tick && (cnt == CNT_W'(OSR - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    // transition logic
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:   if (tick && line_prev && !line) next_state = ST_START;
            ST_START: begin
                if (tick) begin
                    if (line)                            next_state = ST_IDLE;
                    else if (cnt == CNT_W'(HALF - 2))    next_state = ST_DATA;
                end
            end
            ST_DATA: begin
                if (mid && bit_idx == last_idx)
                    next_state = parity_on(cfg_par) ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: if (mid) next_state = ST_STOP;
            ST_STOP:   if (mid) next_state = ST_IDLE;
            default:   next_state = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            par_acc   <= 1'b0;
            par_flag  <= 1'b0;
            line_prev <= 1'b1;
            done      <= 1'b0;
            char_out  <= '0;
            par_bad   <= 1'b0;
            stop_bad  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                line_prev <= line;
                if (state == ST_IDLE || next_state != state || cnt == CNT_W'(OSR - 1))
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end
            unique case (state)
                ST_IDLE: begin
                    if (next_state == ST_START) begin
                        shreg    <= '0;
                        bit_idx  <= '0;
                        par_acc  <= 1'b0;
                        par_flag <= 1'b0;
                    end
                end
                ST_START: ;
                ST_DATA: begin
                    if (mid) begin
                        shreg[bit_idx] <= line;
                        par_acc        <= par_acc ^ line;
                        bit_idx        <= bit_idx + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (mid) par_flag <= ((par_acc ^ line) != (cfg_par == PAR_ODD));
                end
                ST_STOP: begin
                    if (mid) begin
                        done     <= 1'b1;
                        char_out <= shreg;
                        par_bad  <= parity_on(cfg_par) && par_flag;
                        stop_bad <= !line;
                    end
                end
                default: ;
            endcase
        end
    end

    // width mask for the configured word length
    logic [DATA_W-1:0] len_mask;
    always_comb begin
        for (int i = 0; i < DATA_W; i++)
            len_mask[i] = (i <= int'(last_idx));
    end

    assert_false_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && tick && line) |=> (state == ST_IDLE));

    assert_stop_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && mid) |=> (state == ST_IDLE && done));

    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((char_out & ~len_mask) == '0));

endmodule

// File: rtl/rx_holding_reg.sv
module rx_holding_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] char_in,
    input  logic              perr_in,
    input  logic              ferr_in,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] data_q,
    output logic              ready_q,
    output logic              perr_q,
    output logic              ferr_q,
    output logic              ovr_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            ready_q <= 1'b0;
            perr_q  <= 1'b0;
            ferr_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (load) begin
                data_q  <= char_in;
                perr_q  <= perr_in;
                ferr_q  <= ferr_in;
                ready_q <= 1'b1;
                if (ready_q && !rd_ack) ovr_q <= 1'b1;
                else if (rd_ack)        ovr_q <= 1'b0;
            end else if (rd_ack) begin
                ready_q <= 1'b0;
                ovr_q   <= 1'b0;
            end
        end
    end

    assert_ready_from_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_q) |-> $past(load));

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !load) |=> (!ready_q && !ovr_q));

    assert_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ready_q && !rd_ack) |=> ovr_q);

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
    import serial_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              rxd_raw,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              parity_err,
    output logic              frame_err,
    output logic              overrun_err
);
    logic              line_s;
    logic              done;
    logic [DATA_W-1:0] char_w;
    logic              perr_w;
    logic              ferr_w;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n(rst_n),
        .din (rxd_raw),
        .dout(line_s)
    );

    rx_frame_fsm #(.OSR(OSR), .DATA_W(DATA_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .line    (line_s),
        .cfg_len (cfg_len),
        .cfg_par (cfg_par),
        .done    (done),
        .char_out(char_w),
        .par_bad (perr_w),
        .stop_bad(ferr_w)
    );

    rx_holding_reg #(.DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (done),
        .char_in(char_w),
        .perr_in(perr_w),
        .ferr_in(ferr_w),
        .rd_ack (rd_ack),
        .data_q (rx_data),
        .ready_q(rx_ready),
        .perr_q (parity_err),
        .ferr_q (frame_err),
        .ovr_q  (overrun_err)
    );
endmodule

// File: tb/serial_frame_rx_bench.sv
`timescale 1ns/1ps
module serial_frame_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       rxd_raw = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_par = 2'd0;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, parity_err, frame_err, overrun_err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;

    always #4 clk = ~clk;
    always @(posedge clk) tick_en <= ~tick_en;

    serial_frame_rx u_serial_frame_rx (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rxd_raw(rxd_raw),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .rd_ack(rd_ack),
        .rx_data(rx_data), .rx_ready(rx_ready), .parity_err(parity_err),
        .frame_err(frame_err), .overrun_err(overrun_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold_ticks(input logic v, input int n);
        rxd_raw = v;
        repeat (2 * n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input int nbits, input logic [1:0] pm,
                        input bit flip, input logic stop_v, input int stop_ticks);
        logic pb;
        hold_ticks(1'b0, 16);
        for (int i = 0; i < nbits; i++) hold_ticks(b[i], 16);
        if (pm == 2'd1 || pm == 2'd2) begin
            pb = ^(b & 8'((1 << nbits) - 1));
            if (pm == 2'd2) pb = ~pb;
            hold_ticks(pb ^ flip, 16);
        end
        hold_ticks(stop_v, stop_ticks);
        rxd_raw = 1'b1;
    endtask

    task automatic ack();
        @(negedge clk) rd_ack = 1'b1;
        @(negedge clk) rd_ack = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(rx_ready == 0 && parity_err == 0 && frame_err == 0 && overrun_err == 0,
            "R1 flags after reset", {rx_ready, parity_err, frame_err, overrun_err}, 0);
        chk(rx_data == 0, "R1 data after reset", rx_data, 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);

        // sweep: word length x parity mode x byte patterns, with parity flips
        for (int l = 0; l < 4; l++) begin
            for (int p = 0; p < 3; p++) begin
                for (int k = 0; k < 8; k++) begin
                    logic [7:0] b, expd;
                    bit flip;
                    b = (k == 0) ? 8'h00 : (k == 7) ? 8'hFF : 8'((k * 83 + 19) & 255);
                    flip = (p != 0) && (k % 2 == 1);
                    cfg_len = 2'(l);
                    cfg_par = 2'(p);
                    send(b, l + 5, 2'(p), flip, 1'b1, 16);
                    hold_ticks(1'b1, 4);
                    expd = b & 8'((1 << (l + 5)) - 1);
                    chk(rx_ready == 1, "R8 ready after frame", rx_ready, 1);
                    chk(rx_data == expd, "R3 R4 data value", rx_data, expd);
                    chk(parity_err == flip, "R5 parity verdict", parity_err, flip);
                    chk(frame_err == 0, "R6 good stop", frame_err, 0);
                    ack();
                    @(negedge clk);
                    chk(rx_ready == 0 && overrun_err == 0, "R9 ack clears", rx_ready, 0);
                end
            end
        end

        // framing error, char still delivered
        cfg_len = 2'd3; cfg_par = 2'd0;
        send(8'h5A, 8, 2'd0, 0, 1'b0, 16);
        hold_ticks(1'b1, 20);
        chk(frame_err == 1, "R6 low stop", frame_err, 1);
        chk(rx_ready == 1 && rx_data == 8'h5A, "R6 char kept", rx_data, 8'h5A);
        ack();

        // short glitch rejected
        hold_ticks(1'b0, 6);
        hold_ticks(1'b1, 200);
        chk(rx_ready == 0, "R2 glitch rejected", rx_ready, 0);

        // long low accepted, line high afterwards gives all-ones
        hold_ticks(1'b0, 10);
        hold_ticks(1'b1, 200);
        chk(rx_ready == 1 && rx_data == 8'hFF && frame_err == 0, "R3 long low accepted",
            rx_data, 8'hFF);
        ack();

        // shortened stop, back-to-back frames, no read between
        send(8'h3C, 8, 2'd0, 0, 1'b1, 12);
        send(8'hA5, 8, 2'd0, 0, 1'b1, 16);
        hold_ticks(1'b1, 4);
        chk(rx_data == 8'hA5, "R7 second frame after short stop", rx_data, 8'hA5);
        chk(overrun_err == 1, "R10 overrun", overrun_err, 1);
        ack();
        @(negedge clk);
        chk(rx_ready == 0 && overrun_err == 0, "R9 ack clears overrun", overrun_err, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule